// File: doc/BRIEF.md
# Four-Byte Group Interleave Multiplexer

This block merges four byte-wide tributaries, each running at a quarter of the output byte rate, into one byte-wide stream at the full rate. The output takes four consecutive bytes from one tributary before it moves to the next. A complete output frame is therefore sixteen bytes long: the first tributary's four bytes, then the second's, the third's and the fourth's, and then the pattern starts again. Grouping by four is the rule at this rate step. Interleavers at lower rates take one byte per tributary in turn.

Everything runs on a single fast clock. An input enable marks the cycles in which the tributary bytes are valid, which is normally one cycle in four. Each valid word is first registered, then shifted into a four-word pipeline for each tributary. Once four words have arrived they are copied as a set into holding registers. A counter at the output byte rate picks one held byte per cycle and passes it through an output register. A sync input, sampled only on enabled cycles, marks the first word of a group. Every group boundary after it is counted from that word, so each output frame starts with the first tributary's first byte.

Top module: `group_interleave_mux`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `outData` is zero.
- R2: On each enabled cycle the byte in `tribIn[8t+7:8t]` belongs to tributary t. Tributary 0 (bits 7:0) comes out first in every frame and tributary 3 (bits 31:24) comes out last.
- R3: Within a frame the output byte at position n (0 to 15) is byte n mod 4 of the group from tributary n div 4. Byte k of a group is the word presented on the k-th enabled cycle counted from the start of that group.
- R4: If the first word of a group is presented in cycle s, then output position n of that group appears on `outData` in cycle s+16+n.
- R5: `syncIn` has no effect in a cycle where `inEn` is low.
- R6: After reset and before the first enabled cycle with `syncIn` high, enabled words are discarded and `outData` stays zero.
- R7: A sync on an enabled cycle in the middle of a group drops the words of the partial group collected so far. The word presented with that sync becomes byte 0 of a new group.
- R8: After a sync, every fourth enabled word completes a group with no further sync needed, so back-to-back frames follow with no gap.
- R9: When no new group completes, the output keeps cycling through the last complete frame, sixteen bytes per turn.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Output byte-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| inEn | input | 1 | Tributary word valid, nominally one cycle in four |
| syncIn | input | 1 | Marks the first word of a group; honoured only with inEn |
| tribIn | input | 32 | Four tributary bytes, tributary t in bits 8t+7:8t |
| outData | output | 8 | Interleaved output byte |

## Verification
The hardest case to reach is a re-sync that lands in the middle of a group. Before the new group completes, the output must keep repeating the previous frame. The new frame must then start from the byte presented with the sync, and the words taken in before it must be dropped. The stimulus first aligns the block and runs several back-to-back random frames. It then raises sync without enable, which must change nothing. It then raises sync on the second word of a group, and after that it stops the enables so that the last frame repeats. A behavioural model compares the output with the expected byte in every cycle. Explicit checks also confirm the sixteen-cycle latency and the exact byte order of a frame filled with a known pattern.

// File: rtl/gim_pkg.sv
package gim_pkg;
  localparam int BYTE_W    = 8;
  localparam int NUM_TRIB  = 4;
  localparam int GROUP_LEN = 4;
  localparam int FRAME_LEN = NUM_TRIB * GROUP_LEN;
  localparam int SEL_W     = $clog2(FRAME_LEN);
  localparam int IN_W      = NUM_TRIB * BYTE_W;

  // Strobes from control to datapath
  typedef struct packed {
    logic             capture;  // register the tributary word
    logic             shift;    // push registered word into the pipeline
    logic             load;     // copy full pipeline into holding registers
    logic [SEL_W-1:0] sel;      // output byte index within the frame
  } gim_strobe_t;
endpackage

// File: rtl/gim_ctrl.sv
module gim_ctrl
  import gim_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        inEn,
  input  logic        syncIn,
  output gim_strobe_t strobes
);
  localparam int WIDX_W = (GROUP_LEN > 1) ? $clog2(GROUP_LEN) : 1;

  logic              enD;
  logic              syncD;
  logic              aligned;
  logic              holdLoad;
  logic              lastShift;
  logic [WIDX_W-1:0] wordIdx;
  logic [SEL_W-1:0]  outCnt;

  // The shift that brings in the last word of a group
  always_comb begin
    lastShift = enD && (aligned || syncD) &&
                (syncD ? (GROUP_LEN == 1) : (wordIdx == WIDX_W'(GROUP_LEN - 1)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enD      <= 1'b0;
      syncD    <= 1'b0;
      aligned  <= 1'b0;
      holdLoad <= 1'b0;
      wordIdx  <= '0;
      outCnt   <= '0;
    end else begin
      enD   <= inEn;
      syncD <= inEn & syncIn;
      if (enD) begin
        if (syncD) aligned <= 1'b1;
        if (lastShift)  wordIdx <= '0;
        else if (syncD) wordIdx <= WIDX_W'(1);
        else            wordIdx <= wordIdx + WIDX_W'(1);
      end
      holdLoad <= lastShift;
      if (holdLoad || outCnt == SEL_W'(FRAME_LEN - 1)) outCnt <= '0;
      else                                              outCnt <= outCnt + SEL_W'(1);
    end
  end

  always_comb begin
    strobes.capture = inEn;
    strobes.shift   = enD;
    strobes.load    = holdLoad;
    strobes.sel     = outCnt;
  end
endmodule

// File: rtl/gim_datapath.sv
module gim_datapath
  import gim_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IN_W-1:0]   tribIn,
  input  gim_strobe_t       strobes,
  output logic [BYTE_W-1:0] outData
);
  logic [FRAME_LEN*BYTE_W-1:0] heldBus;

  for (genvar t = 0; t < NUM_TRIB; t++) begin : g_trib
    logic [BYTE_W-1:0] inReg;
    logic [BYTE_W-1:0] pipe [GROUP_LEN];
    logic [BYTE_W-1:0] hold [GROUP_LEN];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        inReg <= '0;
        for (int i = 0; i < GROUP_LEN; i++) begin
          pipe[i] <= '0;
          hold[i] <= '0;
        end
      end else begin
        if (strobes.capture) inReg <= tribIn[t*BYTE_W +: BYTE_W];
        if (strobes.shift) begin
          for (int i = 0; i < GROUP_LEN - 1; i++) pipe[i] <= pipe[i+1];
          pipe[GROUP_LEN-1] <= inReg;
        end
        if (strobes.load) begin
          for (int i = 0; i < GROUP_LEN; i++) hold[i] <= pipe[i];
        end
      end
    end

    for (genvar i = 0; i < GROUP_LEN; i++) begin : g_byte
      assign heldBus[(t*GROUP_LEN + i)*BYTE_W +: BYTE_W] = hold[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) outData <= '0;
    else        outData <= heldBus[int'(strobes.sel)*BYTE_W +: BYTE_W];
  end
endmodule

// File: rtl/group_interleave_mux.sv
module group_interleave_mux
  import gim_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inEn,
  input  logic              syncIn,
  input  logic [IN_W-1:0]   tribIn,
  output logic [BYTE_W-1:0] outData
);
  gim_strobe_t strobes;

  gim_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .inEn    (inEn),
    .syncIn  (syncIn),
    .strobes (strobes)
  );

  gim_datapath u_datapath (
    .clk     (clk),
    .rst_n   (rst_n),
    .tribIn  (tribIn),
    .strobes (strobes),
    .outData (outData)
  );
endmodule

// File: rtl/gim_checker.sv
module gim_checker
  import gim_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              inEn,
  input logic              holdLoad,
  input logic [SEL_W-1:0]  outSel,
  input logic [BYTE_W-1:0] outData
);
  logic seenLoad;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        seenLoad <= 1'b0;
    else if (holdLoad) seenLoad <= 1'b1;
  end

  // R4: a freshly loaded frame starts at position 0
  assert_frame_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
    holdLoad |=> outSel == '0);

  // R3: without a load the byte index steps by one and wraps
  assert_sel_advance_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !holdLoad |=> outSel == SEL_W'((int'($past(outSel)) + 1) % FRAME_LEN));

  // R8: loads never come back to back
  assert_load_spaced_R8: assert property (@(posedge clk) disable iff (!rst_n)
    holdLoad |=> !holdLoad);

  // R8: every load follows an enabled word two cycles earlier
  assert_load_after_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    holdLoad |-> $past(inEn, 2));

  // R6: output stays zero until the first frame has been loaded
  assert_quiet_until_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !seenLoad |-> outData == '0);
endmodule

bind group_interleave_mux gim_checker u_gimChecker (
  .clk      (clk),
  .rst_n    (rst_n),
  .inEn     (inEn),
  .holdLoad (strobes.load),
  .outSel   (strobes.sel),
  .outData  (outData)
);

// File: tb/tb_group_interleave_mux.sv
module tb_group_interleave_mux;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        inEn = 1'b0;
  logic        syncIn = 1'b0;
  logic [31:0] tribIn = '0;
  logic [7:0]  outData;

  int    errors = 0;
  int    checks = 0;
  bit    done = 1'b0;
  bit    cmpOn = 1'b0;
  string curReq = "R1";

  // Reference model state
  int          mHold [16];
  int          stash [16];
  int          mCnt;
  int          mOut;
  int          loadAt;
  int          cyc;
  bit          mAligned;
  logic [31:0] words [$];

  group_interleave_mux dut (
    .clk     (clk),
    .rst_n   (rst_n),
    .inEn    (inEn),
    .syncIn  (syncIn),
    .tribIn  (tribIn),
    .outData (outData)
  );

  always #10 clk = ~clk;

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: outData=%02h expected=%02h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // Behavioural reference, one update per clock
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) begin mHold[i] = 0; stash[i] = 0; end
      mCnt = 0; mOut = 0; loadAt = -1; cyc = 0; mAligned = 0;
      words.delete();
    end else begin
      mOut = mHold[mCnt];
      if (cyc == loadAt) begin
        for (int i = 0; i < 16; i++) mHold[i] = stash[i];
        mCnt = 0;
      end else begin
        mCnt = (mCnt + 1) % 16;
      end
      if (inEn) begin
        if (syncIn) begin words.delete(); mAligned = 1; end
        if (mAligned) begin
          words.push_back(tribIn);
          if (words.size() == 4) begin
            for (int t = 0; t < 4; t++)
              for (int j = 0; j < 4; j++)
                stash[t*4 + j] = int'(words[j][t*8 +: 8]);
            loadAt = cyc + 2;
            words.delete();
          end
        end
      end
      cyc++;
    end
  end

  always @(negedge clk) begin
    if (rst_n && cmpOn) check(curReq, int'(outData), mOut);
  end

  task automatic step(bit en, bit sy, logic [31:0] d);
    @(negedge clk);
    #1;
    inEn = en; syncIn = sy; tribIn = d;
  endtask

  task automatic strobe(bit sy, logic [31:0] d);
    step(1'b1, sy, d);
    repeat (3) step(1'b0, 1'b0, ~d);
  endtask

  function automatic logic [31:0] pat(int j);
    return {8'(8'hD0 + j), 8'(8'hC0 + j), 8'(8'hB0 + j), 8'(8'hA0 + j)};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #3;
    check("R1", int'(outData), 0);        // R1 during reset
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #2;
    check("R1", int'(outData), 0);        // R1 first cycle out of reset
    cmpOn = 1'b1;

    // R6: enabled words before any sync are dropped
    curReq = "R6";
    for (int k = 0; k < 8; k++) strobe(1'b0, $urandom);

    // R5: sync without enable does not align the block
    curReq = "R5";
    step(1'b0, 1'b1, 32'h1234_5678);
    repeat (3) step(1'b0, 1'b0, 32'h0);
    for (int k = 0; k < 6; k++) strobe(1'b0, $urandom);

    // R2/R3/R4: known pattern, exact order and latency
    curReq = "R3";
    strobe(1'b1, pat(0));
    for (int j = 1; j < 4; j++) strobe(1'b0, pat(j));
    for (int n = 0; n < 16; n++) begin
      @(negedge clk);
      #2;
      if (n == 0) check("R4", int'(outData), 8'hA0);
      check(n < 4 ? "R2" : "R3", int'(outData), 8'hA0 + (n / 4) * 16 + (n % 4));
    end
    // R9: no new group, the frame repeats
    for (int n = 0; n < 16; n++) begin
      @(negedge clk);
      #2;
      check("R9", int'(outData), 8'hA0 + (n / 4) * 16 + (n % 4));
    end

    // R8: back-to-back frames without further sync
    curReq = "R8";
    strobe(1'b1, $urandom);
    for (int k = 0; k < 19; k++) strobe(1'b0, $urandom);

    // R5: sync on a non-enabled cycle mid-group is ignored
    curReq = "R5";
    step(1'b1, 1'b0, $urandom);
    step(1'b0, 1'b1, $urandom);
    step(1'b0, 1'b0, $urandom);
    step(1'b0, 1'b0, $urandom);
    for (int k = 0; k < 11; k++) strobe(1'b0, $urandom);

    // R7: re-sync on the second word of a group
    curReq = "R7";
    strobe(1'b0, $urandom);
    strobe(1'b1, 32'h4433_2211);
    for (int k = 0; k < 11; k++) strobe(1'b0, $urandom);

    // R9: enables stop, last frame cycles
    curReq = "R9";
    repeat (48) step(1'b0, 1'b0, $urandom);

    cmpOn = 1'b0;
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule